// File: doc/BRIEF.md
# Synchronizable Triangle Carrier Counter

This block produces the triangular carrier used by a pulse-width modulator. An up-down counter climbs from zero to a programmable peak and falls back to zero, so one carrier period lasts twice the peak in clock cycles. For a target switching frequency, set the peak to clock_frequency / (2 × switching_frequency). A new peak is accepted only while the counter sits at zero, so a running period is never cut short.

Several instances can run in lockstep. One instance runs on its own counter and exports its carrier. The others select follower mode and take that carrier on their external input. Every instance detects the extremes of the carrier it is using and raises single-cycle minimum and maximum pulses, which can trigger later logic or interrupts. In follower mode the pulses are derived from the incoming carrier, so they land in the same cycle on every instance that shares that carrier.

An enable input parks the local counter at zero and silences both pulses.

Top module: `tri_carrier`

## Requirements
- R1: While rst_ni is low, carrier_o is 0 and both extreme pulses are low.
- R2: With ext_sel_i = 0 and enable high, carrier_o steps by exactly one per cycle through 0, 1, …, P, P−1, …, 1, 0, 1, … where P is the peak. Each endpoint appears for a single cycle, so the period is 2P cycles. The counter and the peak are both W = 20 bits wide.
- R3: A change of peak_i takes effect only when the counter is at 0. A period already under way runs to its old peak.
- R4: While en_i is low, both pulses stay low. From the cycle after en_i goes low, the local counter reads 0. When en_i returns high, it restarts upward from 0.
- R5: With ext_sel_i = 1, carrier_o equals carrier_ext_i in the same cycle.
- R6: at_max_o is high for exactly one cycle, in the cycle where the carrier first decreases after rising. at_min_o is high for exactly one cycle, in the cycle where the carrier first increases after falling or after reset. This includes the first step of a fresh count.
- R7: In follower mode, the pulses are derived from carrier_ext_i. A follower fed directly with another instance's carrier_o pulses in the same cycles as that instance.
- R8: A peak of 0 holds the counter at 0 and produces no pulses.
- R9: at_min_o and at_max_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low parks the counter at 0 and masks the pulses |
| ext_sel_i | input | 1 | Carrier source: 0 = local counter, 1 = carrier_ext_i |
| peak_i | input | W | Peak count, sampled while the counter is at 0 |
| carrier_ext_i | input | W | Carrier imported from another instance |
| carrier_o | output | W | Active carrier value |
| at_min_o | output | 1 | One-cycle pulse on a carrier minimum |
| at_max_o | output | 1 | One-cycle pulse on a carrier maximum |

## Verification
The counter is tried with these inputs:
- Peaks of 1, 3, 5 and 1000 separate the normal triangle from the shortest two-value carrier.
- A peak changed partway up a ramp separates taking the new peak at zero from truncating the period.
- A zero peak shows that the counter holds still.
- Enable dropped and restored in mid-ramp exposes the park-at-zero and upward restart.
- A follower instance fed from the first compares pass-through and pulse alignment cycle by cycle.
- Arbitrary values forced onto the external input show that the pulses follow the imported carrier rather than the local counter.

// File: rtl/tri_pkg.sv
package tri_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/tri_updown.sv
module tri_updown
  import tri_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] peak_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, pk_q, lim;
  dir_e         dir_q, dir_n;
  logic         at_zero, idle, turn_top, turn_bot;

  always_comb begin
    at_zero  = (cnt_q == '0);
    // peak is only adopted at zero; mid-period the latched copy rules
    lim      = at_zero ? peak_i : pk_q;
    idle     = !en_i || (lim == '0);
    turn_top = (dir_q == DIR_UP) && (cnt_q >= lim);
    turn_bot = (dir_q == DIR_DOWN) && at_zero;
    dir_n    = dir_q;
    if (turn_bot)      dir_n = DIR_UP;
    else if (turn_top) dir_n = DIR_DOWN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pk_q  <= '0;
      dir_q <= DIR_UP;
    end else begin
      if (at_zero) pk_q <= peak_i;
      if (idle) begin
        cnt_q <= '0;
        dir_q <= DIR_UP;
      end else begin
        dir_q <= dir_n;
        cnt_q <= (dir_n == DIR_UP) ? cnt_q + ONE : cnt_q - ONE;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tri_extreme.sv
module tri_extreme
  import tri_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] val_i,
  output logic         min_o,
  output logic         max_o
);
  logic [W-1:0] prev_q;
  dir_e         slope_q;
  logic         rise, fall;

  always_comb begin
    rise  = val_i > prev_q;
    fall  = val_i < prev_q;
    // a turn in slope marks the previous sample as an extreme
    min_o = en_i && rise && (slope_q == DIR_DOWN);
    max_o = en_i && fall && (slope_q == DIR_UP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      slope_q <= DIR_DOWN;
    end else begin
      prev_q <= val_i;
      if (rise)      slope_q <= DIR_UP;
      else if (fall) slope_q <= DIR_DOWN;
    end
  end
endmodule

// File: rtl/tri_carrier.sv
module tri_carrier #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ext_sel_i,
  input  logic [W-1:0] peak_i,
  input  logic [W-1:0] carrier_ext_i,
  output logic [W-1:0] carrier_o,
  output logic         at_min_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt;

  tri_updown #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .peak_i (peak_i),
    .cnt_o  (cnt)
  );

  assign carrier_o = ext_sel_i ? carrier_ext_i : cnt;

  tri_extreme #(.W(W)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .val_i  (carrier_o),
    .min_o  (at_min_o),
    .max_o  (at_max_o)
  );
endmodule

// File: rtl/tri_carrier_chk.sv
module tri_carrier_chk #(
  parameter int W = 20
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         ext_sel_i,
  input logic [W-1:0] carrier_o,
  input logic         at_min_o,
  input logic         at_max_o
);
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(at_min_o && at_max_o)); // R9
  AST_MIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_min_o |=> !at_min_o); // R6
  AST_MAX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_max_o |=> !at_max_o); // R6
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!at_min_o && !at_max_o)); // R4
  AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ext_sel_i) |=> (ext_sel_i || carrier_o == '0)); // R4
  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ext_sel_i && $past(en_i) && !$past(ext_sel_i) && carrier_o != '0)
    |-> (({1'b0, carrier_o} == {1'b0, $past(carrier_o)} + 1'b1) ||
         ({1'b0, $past(carrier_o)} == {1'b0, carrier_o} + 1'b1))); // R2
endmodule

bind tri_carrier tri_carrier_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .ext_sel_i (ext_sel_i),
  .carrier_o (carrier_o),
  .at_min_o  (at_min_o),
  .at_max_o  (at_max_o)
);

// File: tb/sim_tri_carrier.sv
module sim_tri_carrier;
  localparam int W = 20;
  localparam int NV = 13;
  // peak, en0, sel0, ext0, en1, cycles
  localparam int VEC [NV][6] = '{
    '{3, 1, 0, 0, 1, 20}, '{1, 1, 0, 0, 1, 8}, '{5, 1, 0, 0, 1, 25},
    '{5, 0, 0, 0, 1, 4},  '{4, 1, 0, 0, 0, 12}, '{2, 1, 0, 0, 1, 12},
    '{0, 1, 0, 0, 1, 8},  '{6, 1, 1, 123, 1, 3}, '{6, 1, 1, 200, 1, 2},
    '{6, 1, 1, 100, 1, 2}, '{6, 1, 1, 150, 0, 3}, '{6, 1, 0, 0, 1, 30},
    '{1000, 1, 0, 0, 1, 40}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, en0 = 1'b0, sel0 = 1'b0, en1 = 1'b0;
  logic [W-1:0] pk = '0, ext0 = '0;
  logic [W-1:0] c0, c1;
  logic mn0, mx0, mn1, mx1;
  int tot = 0, bad = 0;
  int m_cnt = 0, m_pk = 0, m_prev = 0;
  bit m_up = 1'b1, m_rise = 1'b0;

  always #10 clk_i = ~clk_i;

  tri_carrier #(.W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en0), .ext_sel_i(sel0),
    .peak_i(pk), .carrier_ext_i(ext0), .carrier_o(c0),
    .at_min_o(mn0), .at_max_o(mx0));

  tri_carrier #(.W(W)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en1), .ext_sel_i(1'b1),
    .peak_i(pk), .carrier_ext_i(c0), .carrier_o(c1),
    .at_min_o(mn1), .at_max_o(mx1));

  task automatic chk(input string tag, input int act, input int exp);
    tot++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_c();
    return sel0 ? int'(ext0) : m_cnt;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_pk = 0; m_prev = 0; m_up = 1'b1; m_rise = 1'b0;
  endtask

  task automatic model_step();
    int c, lim;
    c = exp_c();
    if (c > m_prev) m_rise = 1'b1;
    else if (c < m_prev) m_rise = 1'b0;
    m_prev = c;
    lim = (m_cnt == 0) ? int'(pk) : m_pk;
    if (m_cnt == 0) m_pk = int'(pk);
    if (!en0 || lim == 0) begin
      m_cnt = 0; m_up = 1'b1;
    end else if (m_up && m_cnt >= lim) begin
      m_up = 1'b0; m_cnt--;
    end else if (!m_up && m_cnt == 0) begin
      m_up = 1'b1; m_cnt++;
    end else begin
      m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
    end
  endtask

  task automatic compare();
    int c;
    bit emin, emax;
    c = exp_c();
    emin = (c > m_prev) && !m_rise;
    emax = (c < m_prev) && m_rise;
    chk(sel0 ? "R5 carrier" : "R2 carrier", int'(c0), c);
    chk(en0 ? "R6 pulses" : "R4 pulses", int'({mn0, mx0}), int'({en0 & emin, en0 & emax}));
    chk("R5 follower carrier", int'(c1), c);
    chk("R7 follower pulses", int'({mn1, mx1}), int'({en1 & emin, en1 & emax}));
    chk("R9 exclusive", int'(mn0 & mx0), 0);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk_i);
      @(negedge clk_i);
      compare();
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 carrier", int'(c0), 0);
    chk("R1 pulses", int'({mn0, mx0}), 0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    int seq3 [7] = '{1, 2, 3, 2, 1, 0, 1};
    int mn3 [7] = '{1, 0, 0, 0, 0, 0, 1};
    int mx3 [7] = '{0, 0, 0, 1, 0, 0, 0};
    int seqr3 [10] = '{3, 4, 3, 2, 1, 0, 1, 2, 1, 0};

    // R1 and R2: explicit triangle with peak 3
    pk = W'(3); en0 = 1'b1; en1 = 1'b1;
    do_reset();
    for (int i = 0; i < 7; i++) begin
      cyc(1);
      chk("R2 sequence", int'(c0), seq3[i]);
      chk("R6 min pulse", int'(mn0), mn3[i]);
      chk("R6 max pulse", int'(mx0), mx3[i]);
    end

    // R3: peak lowered partway up a ramp
    pk = W'(4);
    do_reset();
    cyc(2);
    pk = W'(2);
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk("R3 peak at zero", int'(c0), seqr3[i]);
    end

    // R8: zero peak holds still
    pk = '0;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R8 carrier", int'(c0), 0);
      chk("R8 pulses", int'({mn0, mx0}), 0);
    end

    // R4: disable in mid-ramp, then restart
    pk = W'(5);
    do_reset();
    cyc(3);
    en0 = 1'b0;
    cyc(1);
    chk("R4 parked", int'(c0), 0);
    cyc(2);
    chk("R4 held", int'(c0), 0);
    en0 = 1'b1;
    cyc(1);
    chk("R4 restart", int'(c0), 1);
    cyc(1);
    chk("R4 restart", int'(c0), 2);

    // table walk against the reference model
    do_reset();
    for (int v = 0; v < NV; v++) begin
      pk   = W'(VEC[v][0]);
      en0  = VEC[v][1][0];
      sel0 = VEC[v][2][0];
      ext0 = W'(VEC[v][3]);
      en1  = VEC[v][4][0];
      cyc(VEC[v][5]);
    end

    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule